// File: doc/BRIEF.md
# Single-Channel Block DMA Engine

This block moves one contiguous run of bytes between system memory and a single peripheral, so the processor does not have to touch each byte. Software writes a start address, a length and a direction through a small word-addressed register port. Writing the control word with its go bit set launches the transfer. The block then serves the peripheral one byte at a time. Each byte is paced by a request line from the peripheral and an acknowledge line back from the engine, and the memory side of each byte goes out on a simple master port.

A block is at most 64 KB long and must lie inside one 64 KB-aligned page. Only the low 16 address bits step, and the page bits stay fixed for the whole run. If a start plus length would run past the end of a page, the start is refused and a sticky error flag is set. When the last byte is done, the engine drops busy, pulses an interrupt for one cycle and sets a sticky terminal-count flag. Software clears both flags through the control word.

Register map (reg_sel): 0 = start address (low ADDR_W bits of reg_wdata), 1 = length minus one (low 16 bits), 2 = control. Control word bits: bit 0 = direction (1: memory to peripheral, 0: peripheral to memory), bit 1 = go, bit 2 = clear flags.

Top module: `dma_block_mover`

## Requirements
- R1: After a synchronous reset, busy, dack, mem_req, irq, tc_flag and err_flag are all 0.
- R2: A control write with go (bit 1) while idle starts a transfer, and busy reads 1 from the next cycle. If start[15:0] plus length-minus-one exceeds 0xFFFF, the transfer is refused instead: err_flag is set, busy stays 0 and no memory or acknowledge activity follows. A block ending exactly at offset 0xFFFF is accepted.
- R3: Peripheral-to-memory (direction 0): each byte takes one cycle with dack high, during which io_rdata is captured. The next cycle has mem_req and mem_we high, with mem_wdata equal to the captured byte. dack and mem_req are never high together.
- R4: Memory-to-peripheral (direction 1): each byte takes one cycle with mem_req high and mem_we low. The next cycle has dack high, with io_wdata equal to the mem_rdata the memory returns one cycle after the request.
- R5: Byte k of a block uses address {start[ADDR_W-1:16], start[15:0]+k}, and exactly length-minus-one plus 1 bytes are moved.
- R6: While dreq is low, no new byte begins: dack and mem_req stay low and busy stays 1. A byte already begun is finished. When dreq returns, the next byte uses the following address.
- R7: One cycle after the last byte's second cycle, busy is 0 and irq is high for exactly one cycle. tc_flag becomes 1 the cycle after that and stays 1 until cleared.
- R8: While busy, writes to the address, length and control registers (including go and direction) do not affect the running transfer and do not set err_flag.
- R9: A control write with clear (bit 2) clears tc_flag and err_flag. If a completion or a refused start falls in the same cycle as the clear, the flag ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 2 | Register select: 0 address, 1 length-1, 2 control |
| reg_wdata | input | REG_W | Register write data |
| dreq | input | 1 | Peripheral asks for bytes |
| dack | output | 1 | Engine is serving the peripheral this cycle |
| io_rdata | input | DATA_W | Byte from peripheral, sampled while dack is high |
| io_wdata | output | DATA_W | Byte to peripheral, valid while dack is high |
| mem_req | output | 1 | Memory access this cycle |
| mem_we | output | 1 | Memory access is a write |
| mem_addr | output | ADDR_W | Memory byte address |
| mem_wdata | output | DATA_W | Memory write data |
| mem_rdata | input | DATA_W | Memory read data, one cycle after a read request |
| irq | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Transfer in progress |
| tc_flag | output | 1 | Sticky terminal-count flag |
| err_flag | output | 1 | Sticky refused-start flag |

## Verification
The flag logic can receive a software clear in the same cycle as a completion, which is when the terminal-count flag would be set. The bench provokes this by watching for the interrupt pulse and writing the clear bit in that exact cycle. It expects tc_flag to read 1 afterwards, and a second clear to return it to 0. A similar overlap happens when go and clear share one control write for a block that crosses a page; in that case err_flag must end up set.

// File: rtl/dma_pkg.sv
package dma_pkg;
  typedef enum logic [1:0] {
    ENG_IDLE = 2'd0,
    ENG_WAIT = 2'd1,
    ENG_PH_A = 2'd2,
    ENG_PH_B = 2'd3
  } eng_state_e;

  localparam logic [1:0] SEL_ADDR  = 2'd0;
  localparam logic [1:0] SEL_COUNT = 2'd1;
  localparam logic [1:0] SEL_CTRL  = 2'd2;

  localparam int CTL_DIR = 0;
  localparam int CTL_GO  = 1;
  localparam int CTL_CLR = 2;
endpackage

// File: rtl/dma_cfg_regs.sv
module dma_cfg_regs
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int PAGE_W = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic              done,
  output logic              start,
  output logic [ADDR_W-1:0] start_addr,
  output logic [PAGE_W-1:0] start_cnt,
  output logic              start_dir,
  output logic              tc_flag,
  output logic              err_flag
);
  logic [ADDR_W-1:0] addr_q;
  logic [PAGE_W-1:0] cnt_q;
  logic [PAGE_W:0]   span;
  logic              crosses;
  logic              ctrl_wr;
  logic              go_req;
  logic              clr_req;

  // end offset of the block; a carry out means it leaves the page
  assign span    = {1'b0, addr_q[PAGE_W-1:0]} + {1'b0, cnt_q};
  assign crosses = span[PAGE_W];
  assign ctrl_wr = reg_wr && (reg_sel == SEL_CTRL);
  assign go_req  = ctrl_wr && reg_wdata[CTL_GO] && !busy;
  assign clr_req = ctrl_wr && reg_wdata[CTL_CLR];

  assign start      = go_req && !crosses;
  assign start_addr = addr_q;
  assign start_cnt  = cnt_q;
  assign start_dir  = reg_wdata[CTL_DIR];

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_q <= '0;
      cnt_q  <= '0;
    end else if (reg_wr && !busy) begin
      if (reg_sel == SEL_ADDR)  addr_q <= reg_wdata[ADDR_W-1:0];
      if (reg_sel == SEL_COUNT) cnt_q  <= reg_wdata[PAGE_W-1:0];
    end
  end

  // setting a flag wins over clearing it in the same cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      tc_flag  <= 1'b0;
      err_flag <= 1'b0;
    end else begin
      if (done)         tc_flag <= 1'b1;
      else if (clr_req) tc_flag <= 1'b0;
      if (go_req && crosses) err_flag <= 1'b1;
      else if (clr_req)      err_flag <= 1'b0;
    end
  end

  AST_REFUSED_STAYS_IDLE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_flag) |-> !busy); // R2
  AST_DONE_SETS_TC: assert property (@(posedge clk) disable iff (rst)
    done |=> tc_flag); // R9
  AST_TC_STICKY: assert property (@(posedge clk) disable iff (rst)
    (tc_flag && !clr_req) |=> tc_flag); // R7
endmodule

// File: rtl/dma_beat_engine.sv
module dma_beat_engine
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] start_addr,
  input  logic [PAGE_W-1:0] start_cnt,
  input  logic              start_dir,
  input  logic              dreq,
  input  logic [DATA_W-1:0] io_rdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              busy,
  output logic              dack,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic [DATA_W-1:0] io_wdata,
  output logic              done
);
  eng_state_e        state_q;
  logic [PAGE_W-1:0] lo_q;
  logic [PAGE_W-1:0] cnt_q;
  logic              dir_q;
  logic [DATA_W-1:0] data_q;
  logic              done_q;
  logic              last_beat;

  assign last_beat = (state_q == ENG_PH_B) && (cnt_q == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= ENG_IDLE;
      lo_q    <= '0;
      cnt_q   <= '0;
      dir_q   <= 1'b0;
      data_q  <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= last_beat;
      case (state_q)
        ENG_IDLE: if (start) begin
          state_q <= ENG_WAIT;
          lo_q    <= start_addr[PAGE_W-1:0];
          cnt_q   <= start_cnt;
          dir_q   <= start_dir;
        end
        ENG_WAIT: if (dreq) state_q <= ENG_PH_A;
        ENG_PH_A: begin
          state_q <= ENG_PH_B;
          if (!dir_q) data_q <= io_rdata;
        end
        ENG_PH_B: begin
          lo_q <= lo_q + PAGE_W'(1);
          if (last_beat) begin
            state_q <= ENG_IDLE;
          end else begin
            cnt_q   <= cnt_q - PAGE_W'(1);
            state_q <= dreq ? ENG_PH_A : ENG_WAIT;
          end
        end
        default: state_q <= ENG_IDLE;
      endcase
    end
  end

  // direction 0: acknowledge first, then write; direction 1: read first, then acknowledge
  assign busy      = (state_q != ENG_IDLE);
  assign dack      = dir_q ? (state_q == ENG_PH_B) : (state_q == ENG_PH_A);
  assign mem_req   = dir_q ? (state_q == ENG_PH_A) : (state_q == ENG_PH_B);
  assign mem_we    = mem_req && !dir_q;
  assign mem_wdata = data_q;
  assign io_wdata  = mem_rdata;
  assign done      = done_q;

  generate
    if (ADDR_W > PAGE_W) begin : g_page
      logic [ADDR_W-PAGE_W-1:0] page_q;
      always_ff @(posedge clk) begin
        if (rst)                              page_q <= '0;
        else if (state_q == ENG_IDLE && start) page_q <= start_addr[ADDR_W-1:PAGE_W];
      end
      assign mem_addr = {page_q, lo_q};

      AST_PAGE_FIXED: assert property (@(posedge clk) disable iff (rst)
        (busy && $past(busy)) |-> $stable(mem_addr[ADDR_W-1:PAGE_W])); // R5
    end else begin : g_flat
      assign mem_addr = lo_q[ADDR_W-1:0];
    end
  endgenerate

  AST_PHASE_EXCL: assert property (@(posedge clk) disable iff (rst)
    !(dack && mem_req)); // R3
  AST_READ_THEN_ACK: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |=> dack); // R4
  AST_STALL_QUIET: assert property (@(posedge clk) disable iff (rst)
    ($past(busy) && busy && !$past(dreq) && !$past(dack) && !$past(mem_req))
      |-> (!dack && !mem_req)); // R6
  AST_IRQ_ONE_CYCLE: assert property (@(posedge clk) disable iff (rst)
    done |=> !done); // R7
  AST_IRQ_IDLE: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy); // R7
  AST_DIR_LOCKED: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy)) |-> $stable(dir_q)); // R8
endmodule

// File: rtl/dma_block_mover.sv
module dma_block_mover
  import dma_pkg::*;
#(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 8,
  parameter int PAGE_W = 16,
  parameter int REG_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_wr,
  input  logic [1:0]        reg_sel,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              dreq,
  output logic              dack,
  input  logic [DATA_W-1:0] io_rdata,
  output logic [DATA_W-1:0] io_wdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic [DATA_W-1:0] mem_rdata,
  output logic              irq,
  output logic              busy,
  output logic              tc_flag,
  output logic              err_flag
);
  logic              start;
  logic [ADDR_W-1:0] start_addr;
  logic [PAGE_W-1:0] start_cnt;
  logic              start_dir;
  logic              done;

  dma_cfg_regs #(
    .ADDR_W(ADDR_W), .PAGE_W(PAGE_W), .REG_W(REG_W)
  ) i_cfg (
    .clk(clk), .rst(rst),
    .reg_wr(reg_wr), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
    .busy(busy), .done(done),
    .start(start), .start_addr(start_addr), .start_cnt(start_cnt),
    .start_dir(start_dir), .tc_flag(tc_flag), .err_flag(err_flag)
  );

  dma_beat_engine #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .PAGE_W(PAGE_W)
  ) i_eng (
    .clk(clk), .rst(rst),
    .start(start), .start_addr(start_addr), .start_cnt(start_cnt),
    .start_dir(start_dir), .dreq(dreq), .io_rdata(io_rdata),
    .mem_rdata(mem_rdata), .busy(busy), .dack(dack),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .io_wdata(io_wdata), .done(done)
  );

  assign irq = done;

  AST_QUIET_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !busy |-> (!dack && !mem_req)); // R2
endmodule

// File: tb/test_dma_block_mover.sv
module test_dma_block_mover;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        reg_wr = 1'b0;
  logic [1:0]  reg_sel = 2'd0;
  logic [31:0] reg_wdata = '0;
  logic        dreq = 1'b0;
  logic        dack;
  logic [7:0]  io_rdata;
  logic [7:0]  io_wdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr;
  logic [7:0]  mem_wdata;
  logic [7:0]  mem_rdata = '0;
  logic        irq, busy, tc_flag, err_flag;

  int          n_chk = 0;
  int          n_bad = 0;
  int          beats = 0;
  int          dreq_mode = 0;
  bit          xfer_on = 1'b0;
  bit          exp_dir = 1'b0;
  logic [31:0] exp_addr = '0;

  always #4 clk = ~clk;

  dma_block_mover i_dma_block_mover (
    .clk(clk), .rst(rst), .reg_wr(reg_wr), .reg_sel(reg_sel),
    .reg_wdata(reg_wdata), .dreq(dreq), .dack(dack), .io_rdata(io_rdata),
    .io_wdata(io_wdata), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .irq(irq), .busy(busy), .tc_flag(tc_flag), .err_flag(err_flag)
  );

  function automatic logic [7:0] mem_pat(input logic [31:0] a);
    return a[7:0] ^ a[15:8] ^ a[23:16] ^ 8'h5A;
  endfunction

  function automatic logic [7:0] io_pat(input logic [31:0] a);
    return (a[7:0] * 8'd7) ^ a[31:24] ^ 8'hC3;
  endfunction

  function automatic logic [31:0] step(input logic [31:0] a);
    return {a[31:16], a[15:0] + 16'd1};
  endfunction

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // peripheral data follows the address the bench expects next
  assign io_rdata = io_pat(exp_addr);

  // memory model: read data one cycle after the request
  always @(posedge clk) begin
    if (mem_req && !mem_we) mem_rdata <= mem_pat(mem_addr);
  end

  // byte monitor
  always @(negedge clk) begin
    if (!rst) begin
      if (!xfer_on) begin
        if (dack || mem_req) chk(1'b0, "R2/R8 activity outside a transfer", {30'd0, dack, mem_req}, 32'd0);
      end else if (!exp_dir) begin
        if (mem_req) begin
          chk(mem_we, "R3 write strobe", 32'(mem_we), 32'd1);
          chk(mem_addr == exp_addr, "R5 write address", mem_addr, exp_addr);
          chk(mem_wdata == io_pat(exp_addr), "R3 write data", 32'(mem_wdata), 32'(io_pat(exp_addr)));
          exp_addr = step(exp_addr);
          beats++;
        end
      end else begin
        if (mem_req) begin
          chk(!mem_we, "R4 read strobe", 32'(mem_we), 32'd0);
          chk(mem_addr == exp_addr, "R5 read address", mem_addr, exp_addr);
        end
        if (dack) begin
          chk(io_wdata == mem_pat(exp_addr), "R4 peripheral data", 32'(io_wdata), 32'(mem_pat(exp_addr)));
          exp_addr = step(exp_addr);
          beats++;
        end
      end
    end
  end

  // request driver
  initial begin
    forever begin
      @(negedge clk);
      case (dreq_mode)
        0:       dreq = 1'b1;
        1:       dreq = (($urandom % 3) != 0);
        default: dreq = 1'b0;
      endcase
    end
  end

  task automatic wr(input logic [1:0] sel, input logic [31:0] d);
    reg_wr = 1'b1;
    reg_sel = sel;
    reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
    reg_wdata = '0;
  endtask

  task automatic start_xfer(input logic [31:0] addr, input logic [15:0] cnt, input bit dir);
    exp_addr = addr;
    exp_dir = dir;
    beats = 0;
    xfer_on = 1'b1;
    wr(2'd0, addr);
    wr(2'd1, {16'd0, cnt});
    wr(2'd2, 32'h2 | 32'(dir));
    chk(busy, "R2 start accepted", 32'(busy), 32'd1);
  endtask

  task automatic wait_done(input logic [31:0] addr, input logic [15:0] cnt, input bit dir,
                           input bit meddle, input bit collide);
    int n = 0;
    bit seen = 1'b0;
    while (n < 4000 && !seen) begin
      if (irq) begin
        seen = 1'b1;
      end else if (meddle && n == 2) begin
        wr(2'd0, addr ^ 32'h0F0F_0100);
        wr(2'd1, 32'(cnt) + 32'd9);
        wr(2'd2, 32'h2 | 32'(!dir));
        chk(!err_flag, "R8 go while busy sets no error", 32'(err_flag), 32'd0);
        n += 3;
      end else begin
        @(negedge clk);
        n++;
      end
    end
    xfer_on = 1'b0;
    if (!seen) begin
      chk(1'b0, "R7 completion timeout", 32'(n), 32'd0);
      return;
    end
    chk(beats == 32'(cnt) + 1, "R5 byte count", 32'(beats), 32'(cnt) + 32'd1);
    chk(!busy, "R7 busy low with irq", 32'(busy), 32'd0);
    if (collide) begin
      wr(2'd2, 32'h4);
      chk(tc_flag, "R9 set wins over clear", 32'(tc_flag), 32'd1);
      wr(2'd2, 32'h4);
      chk(!tc_flag, "R9 clear", 32'(tc_flag), 32'd0);
    end else begin
      @(negedge clk);
      chk(!irq, "R7 irq single cycle", 32'(irq), 32'd0);
      chk(tc_flag, "R7 tc set", 32'(tc_flag), 32'd1);
      repeat (3) @(negedge clk);
      chk(tc_flag, "R7 tc sticky", 32'(tc_flag), 32'd1);
      wr(2'd2, 32'h4);
      chk(!tc_flag, "R9 clear tc", 32'(tc_flag), 32'd0);
    end
  endtask

  task automatic refuse(input logic [31:0] addr, input logic [15:0] cnt, input logic [31:0] ctl);
    xfer_on = 1'b0;
    wr(2'd0, addr);
    wr(2'd1, {16'd0, cnt});
    wr(2'd2, ctl);
    chk(err_flag, "R2 crossing start refused", 32'(err_flag), 32'd1);
    chk(!busy, "R2 no busy after refusal", 32'(busy), 32'd0);
    repeat (6) @(negedge clk);
    chk(!mem_req && !dack, "R2 no activity after refusal", {30'd0, mem_req, dack}, 32'd0);
    wr(2'd2, 32'h4);
    chk(!err_flag, "R9 clear err", 32'(err_flag), 32'd0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog expired");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    bit quiet;
    int b0;
    void'($urandom(32'd20240611));
    repeat (5) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(!busy && !dack && !mem_req && !irq && !tc_flag && !err_flag, "R1 reset state",
        {26'd0, busy, dack, mem_req, irq, tc_flag, err_flag}, 32'd0);

    // directed: both directions, page-edge accept, single byte
    dreq_mode = 0;
    start_xfer(32'h1234_0010, 16'd5, 1'b0);
    wait_done(32'h1234_0010, 16'd5, 1'b0, 1'b0, 1'b0);
    start_xfer(32'hA5A5_0200, 16'd6, 1'b1);
    wait_done(32'hA5A5_0200, 16'd6, 1'b1, 1'b0, 1'b0);
    start_xfer(32'h00C3_FFF0, 16'h000F, 1'b1);
    wait_done(32'h00C3_FFF0, 16'h000F, 1'b1, 1'b0, 1'b0);
    start_xfer(32'h7700_FFFF, 16'd0, 1'b0);
    wait_done(32'h7700_FFFF, 16'd0, 1'b0, 1'b0, 1'b0);

    // refused starts
    refuse(32'h0001_FFFF, 16'd1, 32'h2);
    refuse(32'h0001_FFF0, 16'h0010, 32'h3);
    // go and clear in one write on a crossing block: error must remain set (R9)
    wr(2'd0, 32'h0002_FF00);
    wr(2'd1, 32'h0000_0100);
    wr(2'd2, 32'h6);
    chk(err_flag, "R9 refusal wins over clear", 32'(err_flag), 32'd1);
    wr(2'd2, 32'h4);

    // writes while busy are ignored
    start_xfer(32'h4242_1000, 16'd12, 1'b0);
    wait_done(32'h4242_1000, 16'd12, 1'b0, 1'b1, 1'b0);
    start_xfer(32'h4343_2000, 16'd11, 1'b1);
    wait_done(32'h4343_2000, 16'd11, 1'b1, 1'b1, 1'b0);

    // clear in the completion cycle
    start_xfer(32'h0909_0040, 16'd3, 1'b1);
    wait_done(32'h0909_0040, 16'd3, 1'b1, 1'b0, 1'b1);

    // stall and resume
    dreq_mode = 2;
    start_xfer(32'h5151_0300, 16'd7, 1'b0);
    quiet = 1'b1;
    repeat (10) begin
      @(negedge clk);
      quiet = quiet && !dack && !mem_req && busy;
    end
    chk(quiet, "R6 no bytes before request", 32'(quiet), 32'd1);
    dreq_mode = 0;
    repeat (6) @(negedge clk);
    dreq_mode = 2;
    repeat (5) @(negedge clk);
    b0 = beats;
    quiet = 1'b1;
    repeat (10) begin
      @(negedge clk);
      quiet = quiet && !dack && !mem_req && busy;
    end
    chk(quiet && beats == b0 && b0 > 0, "R6 paused mid block", 32'(beats), 32'(b0));
    dreq_mode = 0;
    wait_done(32'h5151_0300, 16'd7, 1'b0, 1'b0, 1'b0);

    // random blocks with a random request line
    for (int i = 0; i < 14; i++) begin
      logic [15:0] cnt;
      logic [15:0] lo;
      logic [31:0] addr;
      bit dir;
      dir = 1'($urandom % 2);
      cnt = 16'($urandom % 24);
      lo = 16'($urandom % (32'd65536 - 32'(cnt)));
      addr = {16'($urandom), lo};
      dreq_mode = 1;
      start_xfer(addr, cnt, dir);
      wait_done(addr, cnt, dir, 1'b0, (i % 4) == 3);
    end
    dreq_mode = 0;

    repeat (3) @(negedge clk);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule